// File: doc/BRIEF.md
# ISA-Style Bus I/O Slave Decoder

This block is the peripheral side of an I/O device on an ISA-style parallel bus. At the start of each bus cycle the host raises an address-latch strobe while it puts the address and the upper-byte-enable on the bus. The block holds both values at the moment that strobe falls. It then compares the held address against a parameterised base that is aligned to its window. When a read strobe arrives for an address inside the window, the block presents one of its eight 16-bit registers on the byte lanes the cycle asks for. When a write strobe ends, it stores the bytes on those lanes into the selected register.

Cycles that the host marks as DMA cycles, by holding the address-enable line high, get no response. The block drives nothing and stores nothing during them. The physical tristate drivers are not modelled. The block gives one output-enable per byte lane, and an outside pad ring combines each enable with the data. The bus strobes are taken as already synchronised to the block clock.

Top module: `isa_io_slave`

## Requirements
- R1: After reset, all eight registers read as zero and both lane output-enables are low.
- R2: The address and the upper-byte-enable are taken from the bus in the clock cycle where the latch strobe is first seen low after being high. Changes on the address lines while the strobe is high, or after it falls, have no effect on the cycle.
- R3: A cycle is selected only when the held address bits above bit 3 equal the same bits of BASE_ADDR, which gives a 16-byte window. Outside the window neither output-enable rises and no register is written.
- R4: While the address-enable input is high, both output-enables stay low and no write is stored.
- R5: A selected read with held address bit 0 = 0 and upper-byte-enable (active low) = 0 raises both output-enables and presents the whole register on sdOut.
- R6: A selected read with held bit 0 = 0 and upper-byte-enable = 1 raises only sdOeLo. sdOut[7:0] carries the register's low byte and sdOut[15:8] is zero.
- R7: A selected read with held bit 0 = 1 and upper-byte-enable = 0 raises only sdOeHi. sdOut[15:8] carries the register's high byte and sdOut[7:0] is zero.
- R8: With held bit 0 = 1 and upper-byte-enable = 1, no lane takes part: no output-enable rises and a write changes nothing.
- R9: A write is stored in the clock cycle where the write strobe (active low) is first seen high after being low. Only the lanes selected by the rules of R5 to R7 are updated, from the matching bytes of sdIn.
- R10: The register index is held address bits [3:1], so the eight even addresses in the window reach eight distinct registers.
- R11: Both output-enables are low whenever the read strobe (active low) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bale | input | 1 | Address latch strobe, active high |
| sa | input | 16 | Bus address lines |
| aen | input | 1 | DMA cycle marker, active high |
| sbheN | input | 1 | Upper byte enable, active low |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| sdIn | input | 16 | Data from the bus |
| sdOut | output | 16 | Data to the bus; lanes that are not enabled are zero |
| sdOeLo | output | 1 | Output-enable for lane [7:0] |
| sdOeHi | output | 1 | Output-enable for lane [15:8] |

## Verification
Word writes of a distinct value to every register, each followed by a word read-back, show that the index decode reaches eight separate registers. Byte writes and byte reads in each lane pattern separate the low-only, high-only, both-lane and no-lane cases, so a swapped or merged lane shows up as a wrong byte or a wrong enable. Cycles with the DMA marker high, and cycles at addresses just above and just below the window, are each followed by normal reads of the registers they could have touched. Every access moves the address lines away after the latch strobe falls, and one access changes them while the strobe is still high, so any decode that uses the live address instead of the held one reads the wrong register.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture address and upper-byte-enable
    logic wrLo;    // store low lane
    logic wrHi;    // store high lane
  } dpStrobe_t;

  // Byte lanes in use
  typedef struct packed {
    logic lo;
    logic hi;
  } laneSel_t;

endpackage

// File: rtl/isa_io_edge.sv
module isa_io_edge #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= RESET_VAL;
    else       prevQ <= din;
  end

  assign rise = !prevQ && din;
  assign fall = prevQ && !din;
endmodule

// File: rtl/isa_io_ctrl.sv
module isa_io_ctrl
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_COUNT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300,
  localparam int IDX_W = $clog2(REG_COUNT),
  localparam int OFF_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bale,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  input  logic [ADDR_W-1:0] addrHold,
  input  logic              sbheHold,
  output dpStrobe_t         strobe,
  output laneSel_t          rdLane,
  output logic [IDX_W-1:0]  regIdx
);
  logic baleRise, baleFall, iowRise, iowFall;
  logic hit, active;
  laneSel_t lane;

  isa_io_edge #(.RESET_VAL(1'b0)) u_baleEdge (
    .clk(clk), .rstN(rstN), .din(bale), .rise(baleRise), .fall(baleFall)
  );

  isa_io_edge #(.RESET_VAL(1'b1)) u_iowEdge (
    .clk(clk), .rstN(rstN), .din(iowN), .rise(iowRise), .fall(iowFall)
  );

  assign hit    = (addrHold[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign active = hit && !aen;

  assign lane.lo = !addrHold[0];
  assign lane.hi = !sbheHold;

  assign regIdx = addrHold[OFF_W-1:1];

  always_comb begin
    strobe.latch = baleFall;
    strobe.wrLo  = iowRise && active && lane.lo;
    strobe.wrHi  = iowRise && active && lane.hi;
    rdLane.lo    = !iorN && active && lane.lo;
    rdLane.hi    = !iorN && active && lane.hi;
  end

  logic unusedEdges;
  assign unusedEdges = baleRise ^ iowFall;
endmodule

// File: rtl/isa_io_dp.sv
module isa_io_dp
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_COUNT = 8,
  localparam int IDX_W = $clog2(REG_COUNT),
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  laneSel_t          rdLane,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] sa,
  input  logic              sbheN,
  input  logic [DATA_W-1:0] sdIn,
  output logic [ADDR_W-1:0] addrHold,
  output logic              sbheHold,
  output logic [DATA_W-1:0] sdOut,
  output logic              sdOeLo,
  output logic              sdOeHi
);
  logic [DATA_W-1:0] regView [REG_COUNT];
  logic [DATA_W-1:0] selWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      sbheHold <= 1'b1;
    end else if (strobe.latch) begin
      addrHold <= sa;
      sbheHold <= sbheN;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    logic [DATA_W-1:0] word;
    logic selMe;
    assign selMe = (regIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        word <= '0;
      end else begin
        if (selMe && strobe.wrLo) word[HALF-1:0]      <= sdIn[HALF-1:0];
        if (selMe && strobe.wrHi) word[DATA_W-1:HALF] <= sdIn[DATA_W-1:HALF];
      end
    end

    assign regView[g] = word;
  end

  assign selWord = regView[regIdx];

  assign sdOut  = {rdLane.hi ? selWord[DATA_W-1:HALF] : {HALF{1'b0}},
                   rdLane.lo ? selWord[HALF-1:0]      : {HALF{1'b0}}};
  assign sdOeLo = rdLane.lo;
  assign sdOeHi = rdLane.hi;
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_COUNT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bale,
  input  logic [ADDR_W-1:0] sa,
  input  logic              aen,
  input  logic              sbheN,
  input  logic              iorN,
  input  logic              iowN,
  input  logic [DATA_W-1:0] sdIn,
  output logic [DATA_W-1:0] sdOut,
  output logic              sdOeLo,
  output logic              sdOeHi
);
  dpStrobe_t         strobe;
  laneSel_t          rdLane;
  logic [IDX_W-1:0]  regIdx;
  logic [ADDR_W-1:0] addrHold;
  logic              sbheHold;

  isa_io_ctrl #(
    .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bale(bale), .aen(aen), .iorN(iorN), .iowN(iowN),
    .addrHold(addrHold), .sbheHold(sbheHold),
    .strobe(strobe), .rdLane(rdLane), .regIdx(regIdx)
  );

  isa_io_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdLane(rdLane), .regIdx(regIdx),
    .sa(sa), .sbheN(sbheN), .sdIn(sdIn),
    .addrHold(addrHold), .sbheHold(sbheHold),
    .sdOut(sdOut), .sdOeLo(sdOeLo), .sdOeHi(sdOeHi)
  );
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int ADDR_W = 16,
  parameter int REG_COUNT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300,
  localparam int OFF_W = $clog2(REG_COUNT) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              bale,
  input logic [ADDR_W-1:0] sa,
  input logic              aen,
  input logic              sbheN,
  input logic              iorN,
  input logic              sdOeLo,
  input logic              sdOeHi
);
  // Independent shadow of the latched cycle attributes
  logic              baleD;
  logic [ADDR_W-1:0] shAddr;
  logic              shSbhe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baleD  <= 1'b0;
      shAddr <= '0;
      shSbhe <= 1'b1;
    end else begin
      baleD <= bale;
      if (baleD && !bale) begin
        shAddr <= sa;
        shSbhe <= sbheN;
      end
    end
  end

  // R4
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> !(sdOeLo || sdOeHi));

  // R11
  read_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    iorN |-> !(sdOeLo || sdOeHi));

  // R7
  hi_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdOeHi |-> !shSbhe);

  // R6
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdOeLo |-> !shAddr[0]);

  // R3
  window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdOeLo || sdOeHi) |-> (shAddr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]));
endmodule

bind isa_io_slave isa_io_slave_chk #(
  .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .bale(bale), .sa(sa), .aen(aen), .sbheN(sbheN),
  .iorN(iorN), .sdOeLo(sdOeLo), .sdOeHi(sdOeHi)
);

// File: tb/isa_io_slave_test.sv
module isa_io_slave_test;
  localparam logic [15:0] BASE = 16'h0300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bale = 1'b0;
  logic [15:0] sa = '0;
  logic aen = 1'b0;
  logic sbheN = 1'b1;
  logic iorN = 1'b1;
  logic iowN = 1'b1;
  logic [15:0] sdIn = '0;
  logic [15:0] sdOut;
  logic sdOeLo, sdOeHi;

  always #10 clk = ~clk;   // 50 MHz

  isa_io_slave #(.BASE_ADDR(BASE)) uut (
    .clk(clk), .rstN(rstN), .bale(bale), .sa(sa), .aen(aen), .sbheN(sbheN),
    .iorN(iorN), .iowN(iowN), .sdIn(sdIn),
    .sdOut(sdOut), .sdOeLo(sdOeLo), .sdOeHi(sdOeHi)
  );

  typedef struct {
    string       tag;
    logic        oeLo;
    logic        oeHi;
    logic [15:0] data;
  } expItem_t;

  expItem_t    sbq[$];
  logic [15:0] model [8];
  int checks = 0;
  int fails = 0;
  bit sampleNow = 1'b0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Latch a cycle: address shown first as preAddr, then addr, while bale is high
  task automatic startCycle(logic [15:0] preAddr, logic [15:0] addr, logic sbhe, logic dma);
    aen = dma; bale = 1'b1; sa = preAddr; sbheN = sbhe;
    step();
    sa = addr;
    step();
    bale = 1'b0;
    step();
    sa = ~addr;          // live lines move away after the latch
    sbheN = ~sbhe;
  endtask

  function automatic bit inWin(logic [15:0] addr);
    return addr[15:4] == BASE[15:4];
  endfunction

  task automatic busRead(string tag, logic [15:0] addr, logic sbhe, logic dma,
                         logic [15:0] preAddr);
    expItem_t e;
    bit act;
    startCycle(preAddr, addr, sbhe, dma);
    act = inWin(addr) && !dma;
    e.tag  = tag;
    e.oeLo = act && !addr[0];
    e.oeHi = act && !sbhe;
    e.data = {e.oeHi ? model[addr[3:1]][15:8] : 8'h00,
              e.oeLo ? model[addr[3:1]][7:0]  : 8'h00};
    iorN = 1'b0;
    sbq.push_back(e);
    sampleNow = 1'b1;
    step();
    sampleNow = 1'b0;
    iorN = 1'b1;
    aen = 1'b0;
    #5;
    // R11: enables drop once the read strobe is high
    chk({tag, " R11 idle"}, {sdOeLo, sdOeHi, 16'h0}, 18'h0);
    step();
  endtask

  task automatic busWrite(logic [15:0] addr, logic sbhe, logic dma, logic [15:0] d);
    startCycle(addr, addr, sbhe, dma);
    sdIn = d;
    iowN = 1'b0;
    step();
    step();
    iowN = 1'b1;
    step();
    aen = 1'b0;
    sdIn = 16'hDEAD;
    if (inWin(addr) && !dma) begin
      if (!addr[0]) model[addr[3:1]][7:0]  = d[7:0];
      if (!sbhe)    model[addr[3:1]][15:8] = d[15:8];
    end
    step();
  endtask

  // Monitor: pops the scoreboard while a read is on the bus
  initial begin
    forever begin
      @(negedge clk);
      if (sampleNow) begin
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard empty actual=%h expected=none", sdOut);
        end else begin
          expItem_t e;
          e = sbq.pop_front();
          chk(e.tag, {sdOeLo, sdOeHi, sdOut}, {e.oeLo, e.oeHi, e.data});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1: reset outputs
    chk("R1 reset enables", {sdOeLo, sdOeHi, 16'h0}, 18'h0);
    for (int i = 0; i < 8; i++)
      busRead("R1 reset register", BASE + 16'(2*i), 1'b0, 1'b0, 16'h0000);

    // R9 R10: distinct word writes then word read-back (R5)
    for (int i = 0; i < 8; i++)
      busWrite(BASE + 16'(2*i), 1'b0, 1'b0, 16'h1111 * 16'(i + 1) ^ 16'h8040);
    for (int i = 0; i < 8; i++)
      busRead("R5 R10 word read", BASE + 16'(2*i), 1'b0, 1'b0, 16'hFFFF);

    // R9: byte writes on each lane
    busWrite(BASE + 16'h4, 1'b1, 1'b0, 16'h55AA);   // low byte of reg2
    busRead("R9 low-lane write", BASE + 16'h4, 1'b0, 1'b0, 16'h0000);
    busWrite(BASE + 16'h7, 1'b0, 1'b0, 16'hC33C);   // high byte of reg3
    busRead("R9 high-lane write", BASE + 16'h6, 1'b0, 1'b0, 16'h0000);

    // R6 R7 R8: read lane patterns
    busRead("R6 low-only read", BASE + 16'hA, 1'b1, 1'b0, 16'h0000);
    busRead("R7 high-only read", BASE + 16'hB, 1'b0, 1'b0, 16'h0000);
    busRead("R8 no-lane read", BASE + 16'hB, 1'b1, 1'b0, 16'h0000);
    busWrite(BASE + 16'h9, 1'b1, 1'b0, 16'h0F0F);
    busRead("R8 no-lane write ignored", BASE + 16'h8, 1'b0, 1'b0, 16'h0000);

    // R4: DMA cycles
    busRead("R4 dma read quiet", BASE + 16'h2, 1'b0, 1'b1, 16'h0000);
    busWrite(BASE + 16'h2, 1'b0, 1'b1, 16'hBEEF);
    busRead("R4 dma write ignored", BASE + 16'h2, 1'b0, 1'b0, 16'h0000);

    // R3: just outside the window on either side
    busRead("R3 above window", BASE + 16'h10, 1'b0, 1'b0, 16'h0000);
    busRead("R3 below window", BASE - 16'h2, 1'b0, 1'b0, 16'h0000);
    busWrite(BASE + 16'h10, 1'b0, 1'b0, 16'hABCD);
    busWrite(BASE - 16'h2, 1'b0, 1'b0, 16'h9876);
    busRead("R3 outside write ignored r0", BASE, 1'b0, 1'b0, 16'h0000);
    busRead("R3 outside write ignored r7", BASE + 16'hE, 1'b0, 1'b0, 16'h0000);

    // R2: address changes while the latch strobe is high
    busRead("R2 latch at strobe fall", BASE + 16'hC, 1'b0, 1'b0, BASE + 16'h2);

    repeat (3) step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule